// File: doc/BRIEF.md
# Transmit Mailbox Priority Status Tracker

This block watches a bank of message mailboxes while a transmit arbitration pass runs. A start strobe opens the pass. The block then reads one mailbox per clock, lowest index first, and keeps a running summary of what it has seen. When the end strobe closes the pass, the block publishes a status word. The word holds three things: which mailbox is the weakest transmit candidate, or the first free one; whether any free mailbox exists; and whether those two results can be trusted.

Trust is lost in three cases. A new pass starts. The CPU writes any mailbox control word. The CPU writes a mailbox during a pass after the scan has already read that mailbox. A write to a mailbox the scan has not yet reached does not cost validity, because the scan will pick up the new contents when it gets there. Between passes, a successful transmission can overwrite the reported index, as long as no free mailbox was found.

Top module: `txprio_tracker`

## Requirements
- R1: After reset the status word is all zeros. The index sits in bits 22..16, the valid flag in bit 14 and the inactive flag in bit 13. Every other bit always reads 0.
- R2: A mailbox whose code is 4'b0000 or 4'b1000 is inactive. If a completed pass saw any such mailbox, the inactive flag is 1 and the index is the lowest-numbered inactive mailbox.
- R3: If no mailbox is inactive and the mode bit `lowbuf_mode` is 0, the index is the transmit mailbox with the largest arbitration value. A transmit mailbox has code 4'b1100. On equal values, the lower index wins.
- R4: If no mailbox is inactive and `lowbuf_mode` is 1, the index is the highest-numbered transmit mailbox (code 4'b1100).
- R5: A mailbox whose in-transmission bit is set is ignored when the block looks for inactive mailboxes and for transmit candidates.
- R6: The valid flag reads 0 in the cycle after a start strobe. It also reads 0 in the cycle after any CPU control-word write.
- R7: On the end strobe of a fully scanned pass, the valid flag is set, provided there was a candidate and no blocking write. A write during the pass to a mailbox the scan has not yet read does not block.
- R8: A CPU write during a pass blocks the valid flag if its index is less than or equal to the mailbox being read in that cycle. Any write after the scan has finished also blocks.
- R9: If a completed pass finds neither an inactive mailbox nor an eligible transmit mailbox, the valid flag and the inactive flag are both 0 and the index keeps its previous value.
- R10: A transmit-success event loads its mailbox number into the index while the inactive flag is 0. It has no effect while the inactive flag is 1.
- R11: An end strobe that arrives before every mailbox has been read leaves the valid flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_code | input | 4*NUM_MB | 4-bit code of each mailbox, mailbox i at bits 4i+3..4i |
| mb_arb | input | ARB_W*NUM_MB | Arbitration value of each mailbox |
| mb_busy | input | NUM_MB | Mailbox is being transmitted |
| arb_start | input | 1 | Opens an arbitration pass |
| arb_end | input | 1 | Closes the arbitration pass |
| cpu_wr | input | 1 | CPU writes a mailbox control word |
| cpu_idx | input | 7 | Mailbox index of the CPU write |
| lowbuf_mode | input | 1 | Selects the highest-index fallback |
| tx_ok | input | 1 | A frame was sent successfully |
| tx_idx | input | 7 | Mailbox number of the sent frame |
| status | output | 32 | Packed status word |

## Verification
The hardest case to reach is the boundary between a harmless write and a blocking write. It depends on where the scan pointer is in the exact cycle the write is sampled. The pass task therefore counts clocks from the start strobe, so it always knows which mailbox is being read. It then places the write at a chosen scan step. This exercises three cases: an index ahead of the pointer, an index equal to it, and an index behind it.

// File: rtl/txprio_tracker.sv
module txprio_tracker #(
  parameter int NUM_MB = 16,
  parameter int ARB_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4*NUM_MB-1:0]     mb_code,
  input  logic [ARB_W*NUM_MB-1:0] mb_arb,
  input  logic [NUM_MB-1:0]       mb_busy,
  input  logic                    arb_start,
  input  logic                    arb_end,
  input  logic                    cpu_wr,
  input  logic [6:0]              cpu_idx,
  input  logic                    lowbuf_mode,
  input  logic                    tx_ok,
  input  logic [6:0]              tx_idx,
  output logic [31:0]             status
);
  localparam int PW = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;
  localparam logic [PW-1:0] LAST = PW'(NUM_MB - 1);

  logic [3:0]       code_a [NUM_MB];
  logic [ARB_W-1:0] arb_a  [NUM_MB];

  for (genvar g = 0; g < NUM_MB; g++) begin : g_unpack
    assign code_a[g] = mb_code[g*4 +: 4];
    assign arb_a[g]  = mb_arb[g*ARB_W +: ARB_W];
  end

  logic [PW-1:0]    ptr, inact_idx, best_idx, last_tx;
  logic [ARB_W-1:0] best_arb;
  logic             scanning, scan_done, blocked, found_inact, have_tx;
  logic [6:0]       lptm;
  logic             vps, imb;

  logic [3:0]       cur_code;
  logic [ARB_W-1:0] cur_arb;
  logic             cur_inact, cur_tx;
  logic [6:0]       ptr_x;
  logic [PW-1:0]    sel;
  logic             cand, wr_blocks, closing;

  assign cur_code  = code_a[ptr];
  assign cur_arb   = arb_a[ptr];
  assign cur_inact = !mb_busy[ptr] && (cur_code[2:0] == 3'b000);
  assign cur_tx    = !mb_busy[ptr] && (cur_code == 4'b1100);
  assign ptr_x     = 7'(ptr);
  assign sel       = found_inact ? inact_idx : (lowbuf_mode ? last_tx : best_idx);
  assign cand      = found_inact || have_tx;
  assign wr_blocks = cpu_wr && ((scanning && cpu_idx <= ptr_x) || scan_done);
  assign closing   = arb_end && scan_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0; inact_idx <= '0; best_idx <= '0; last_tx <= '0;
      best_arb <= '0; scanning <= 1'b0; scan_done <= 1'b0;
      blocked <= 1'b0; found_inact <= 1'b0; have_tx <= 1'b0;
      lptm <= '0; vps <= 1'b0; imb <= 1'b0;
    end else if (arb_start) begin
      ptr <= '0; scanning <= 1'b1; scan_done <= 1'b0; blocked <= 1'b0;
      found_inact <= 1'b0; have_tx <= 1'b0; vps <= 1'b0;
    end else begin
      if (scanning) begin
        if (cur_inact && !found_inact) begin
          found_inact <= 1'b1;
          inact_idx   <= ptr;
        end
        if (cur_tx) begin
          have_tx <= 1'b1;
          last_tx <= ptr;
          if (!have_tx || cur_arb > best_arb) begin
            best_arb <= cur_arb;
            best_idx <= ptr;
          end
        end
        if (ptr == LAST) begin
          scanning  <= 1'b0;
          scan_done <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
      if (cpu_wr) vps <= 1'b0;
      if (wr_blocks) blocked <= 1'b1;
      if (arb_end) begin
        scanning  <= 1'b0;
        scan_done <= 1'b0;
      end
      if (closing) begin
        imb <= found_inact;
        if (cand) lptm <= 7'(sel);
        vps <= cand && !blocked && !wr_blocks;
      end else if (tx_ok && !imb) begin
        lptm <= tx_idx;
      end
    end
  end

  assign status = {9'b0, lptm, 1'b0, vps, imb, 13'b0};
endmodule

module txprio_tracker_chk #(
  parameter int NUM_MB = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        arb_start,
  input logic        arb_end,
  input logic        cpu_wr,
  input logic        tx_ok,
  input logic [6:0]  tx_idx,
  input logic [31:0] status
);
  AST_START_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    arb_start |=> !status[14]); // R6
  AST_WRITE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !status[14]); // R6
  AST_VALID_RISES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[14]) |-> $past(arb_end)); // R7
  AST_VALID_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_start && !arb_end && !cpu_wr) |=> status[14] == $past(status[14])); // R7
  AST_TX_LOADS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && !status[13] && !arb_end) |=> status[22:16] == $past(tx_idx)); // R10
  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (status[14] && status[13]) |-> status[22:16] < 7'(NUM_MB)); // R2
endmodule

bind txprio_tracker txprio_tracker_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk(clk), .rst_n(rst_n), .arb_start(arb_start), .arb_end(arb_end),
  .cpu_wr(cpu_wr), .tx_ok(tx_ok), .tx_idx(tx_idx), .status(status)
);

// File: tb/txprio_tracker_test.sv
`timescale 1ns/1ps
module txprio_tracker_test;
  localparam int N = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]    code [N];
  logic [AW-1:0] arb  [N];
  logic [N-1:0]  busy = '0;
  logic [4*N-1:0]  mb_code;
  logic [AW*N-1:0] mb_arb;
  logic arb_start = 0, arb_end = 0, cpu_wr = 0, lowbuf_mode = 0, tx_ok = 0;
  logic [6:0] cpu_idx = '0, tx_idx = '0;
  logic [31:0] status;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign mb_code[g*4 +: 4]   = code[g];
    assign mb_arb[g*AW +: AW]  = arb[g];
  end

  txprio_tracker #(.NUM_MB(N), .ARB_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .mb_code(mb_code), .mb_arb(mb_arb), .mb_busy(busy),
    .arb_start(arb_start), .arb_end(arb_end), .cpu_wr(cpu_wr), .cpu_idx(cpu_idx),
    .lowbuf_mode(lowbuf_mode), .tx_ok(tx_ok), .tx_idx(tx_idx), .status(status));

  function automatic logic [31:0] word(input int idx, input bit v, input bit i);
    return {9'b0, 7'(idx), 1'b0, v, i, 13'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic all_codes(input logic [3:0] c);
    for (int i = 0; i < N; i++) begin code[i] = c; arb[i] = AW'(10 + i); end
    busy = '0;
  endtask

  task automatic pass(input int wr_at, input int wr_idx, input int end_at);
    @(negedge clk); arb_start = 1;
    @(negedge clk); arb_start = 0;
    check("R6 start", {31'b0, status[14]}, 32'd0);
    for (int m = 0; m < N; m++) begin
      cpu_wr = (m == wr_at); cpu_idx = 7'(wr_idx);
      arb_end = (m == end_at);
      @(negedge clk);
      cpu_wr = 0; arb_end = 0;
      if (m == end_at) return;
    end
    arb_end = 1;
    @(negedge clk); arb_end = 0;
  endtask

  task automatic t_reset;
    check("R1 reset", status, 32'd0);
  endtask

  task automatic t_inactive;
    all_codes(4'b1100); code[3] = 4'b0000; code[5] = 4'b1000;
    pass(-1, 0, -1);
    check("R2 lowest inactive", status, word(3, 1, 1));
    busy[3] = 1'b1;
    pass(-1, 0, -1);
    check("R5 busy inactive skipped", status, word(5, 1, 1));
  endtask

  task automatic t_arb;
    all_codes(4'b1100); code[1] = 4'b0100;
    arb[0] = 250; busy[0] = 1'b1; arb[2] = 200; arb[6] = 200;
    lowbuf_mode = 0;
    pass(-1, 0, -1);
    check("R3 max arb, tie low, R5 busy out", status, word(2, 1, 0));
  endtask

  task automatic t_lowbuf;
    all_codes(4'b1100); code[7] = 4'b0100; busy[6] = 1'b1;
    lowbuf_mode = 1;
    pass(-1, 0, -1);
    check("R4 highest tx index", status, word(5, 1, 0));
    lowbuf_mode = 0;
  endtask

  task automatic t_none;
    all_codes(4'b0100); code[4] = 4'b1100; busy[4] = 1'b1;
    pass(-1, 0, -1);
    check("R9 no candidate", status, word(5, 0, 0));
  endtask

  task automatic t_txload;
    @(negedge clk); tx_ok = 1; tx_idx = 7'd6;
    @(negedge clk); tx_ok = 0;
    check("R10 tx load", status, word(6, 0, 0));
    all_codes(4'b1100); code[3] = 4'b0000;
    pass(-1, 0, -1);
    check("R2 inactive again", status, word(3, 1, 1));
    @(negedge clk); tx_ok = 1; tx_idx = 7'd1;
    @(negedge clk); tx_ok = 0;
    check("R10 tx ignored", status, word(3, 1, 1));
  endtask

  task automatic t_writes;
    all_codes(4'b1100); arb[4] = 99;
    pass(2, 6, -1);
    check("R7 write ahead keeps valid", status, word(4, 1, 0));
    @(negedge clk); cpu_wr = 1; cpu_idx = 7'd0;
    @(negedge clk); cpu_wr = 0;
    check("R6 write clears", status, word(4, 0, 0));
    pass(4, 4, -1);
    check("R8 write at pointer blocks", status, word(4, 0, 0));
    pass(5, 1, -1);
    check("R8 write behind blocks", status, word(4, 0, 0));
    pass(-1, 0, -1);
    check("R7 clean pass", status, word(4, 1, 0));
    pass(-1, 0, 3);
    check("R11 early end", {31'b0, status[14]}, 32'd0);
  endtask

  initial begin
    all_codes(4'b0100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_inactive();
    t_arb();
    t_lowbuf();
    t_none();
    t_txload();
    t_writes();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule